// File: doc/BRIEF.md
# Hybrid Three-Level Leg PWM Modulator

This block produces the eighteen gate commands of a three-phase hybrid active neutral-point-clamped inverter. Each phase leg has four slow IGBT gates (an upper outer/clamp pair and a lower clamp/outer pair) and two fast MOSFET gates. One digital reference word per phase comes in. It is already offset and scaled so that mid-scale marks the zero crossing of the fundamental. The block compares it against a shared symmetric triangular carrier.

The two device classes switch on different timescales. The IGBT pairs change only when the reference changes sign, so they switch at the fundamental frequency. The MOSFET pair is modulated by the carrier comparison at the carrier rate. Every gate passes through its own dead-band stage. That stage delays turn-on by a class-specific number of clocks and passes turn-off at once, so complementary devices never conduct together.

With the default parameters the carrier peak is 500, so the period is 1000 clocks. At a 30 MHz clock this gives a 30 kHz carrier. The IGBT dead band is 9 clocks and the MOSFET dead band is 3 clocks.

Top module: `hnpc_modulator`

## Requirements
- R1: The carrier counts up by one per enabled clock from 0 to PEAK and then down by one back to 0, for a period of 2*PEAK clocks. It starts at 0 on the first clock after reset or enable is released.
- R2: A phase reference is captured only on the clock in which the carrier is 0. Changes at any other time have no effect on the gates until the next capture.
- R3: A captured reference at or above mid-scale (PEAK) is the positive half. In the positive half the upper outer (bit 0) and upper clamp (bit 1) gates are on and the lower clamp (bit 2) and lower outer (bit 3) gates are off. Below mid-scale the roles swap.
- R4: In the positive half the upper MOSFET (bit 4) is demanded while (reference - PEAK) is greater than the carrier, and the lower MOSFET (bit 5) is demanded otherwise. In the negative half the lower MOSFET is demanded while (PEAK - reference) is greater than the carrier, and the upper MOSFET otherwise. A gate turns off two clocks after the carrier holds the value that ends its demand.
- R5: Every gate turns on a fixed number of clocks later than it turns off: DT_IGBT for bits 0 to 3 and DT_FET for bits 4 and 5. Both MOSFETs of a leg are never on together, and no upper IGBT is on together with a lower IGBT. A gate rises only after its complements have been off for at least the class dead band.
- R6: A demand pulse lasting the class dead band or fewer clocks produces no output pulse. A longer one yields an output pulse that is shorter by the dead band.
- R7: While reset is high or enable is low, all gate outputs are 0 on the following clock and the carrier is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock, one carrier step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces all gates off and parks the carrier |
| ref_in | input | NPH*REF_W (30) | Per-phase reference, phase p at bits [p*REF_W +: REF_W], range 0..2*PEAK |
| gates | output | NPH*6 (18) | Gate commands, leg p at bits [p*6 +: 6]: bit0 upper outer, bit1 upper clamp, bit2 lower clamp, bit3 lower outer, bit4 upper MOSFET, bit5 lower MOSFET |

## Verification
The assertions assume that each reference word stays within 0..2*PEAK, and that enable and reset are synchronous levels that may change on any cycle. The stimulus drives only in-range references. It changes them on the falling clock edge, either in steady holds that span several carrier periods or in bursts that move in the middle of a period to exercise the capture rule. Enable is dropped once in mid-period to check that the carrier restarts from zero.

// File: rtl/hnpc_pkg.sv
package hnpc_pkg;

    // Default carrier peak: one period spans 2*CAR_PEAK clocks.
    localparam int CAR_PEAK      = 500;
    // Default dead bands in clocks.
    localparam int DT_SLOW       = 9;
    localparam int DT_FAST       = 3;
    // Leg structure.
    localparam int NUM_PHASES    = 3;
    localparam int SLOW_PER_LEG  = 4;
    localparam int FAST_PER_LEG  = 2;
    localparam int GATES_PER_LEG = SLOW_PER_LEG + FAST_PER_LEG;

    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } car_dir_e;

    // Packed so that outer_hi is bit 0 and fet_lo is bit 5.
    typedef struct packed {
        logic fet_lo;
        logic fet_hi;
        logic outer_lo;
        logic clamp_lo;
        logic clamp_hi;
        logic outer_hi;
    } leg_gates_t;

    // Map half-cycle sign and fast comparison result onto the six devices.
    function automatic leg_gates_t leg_decode(input logic positive, input logic fast_on);
        leg_gates_t g;
        g.outer_hi = positive;
        g.clamp_hi = positive;
        g.clamp_lo = ~positive;
        g.outer_lo = ~positive;
        g.fet_hi   = positive ? fast_on : ~fast_on;
        g.fet_lo   = positive ? ~fast_on : fast_on;
        return g;
    endfunction

endpackage

// File: rtl/hnpc_carrier.sv
module hnpc_carrier
    import hnpc_pkg::*;
#(
    parameter int PEAK = CAR_PEAK
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en,
    output logic [$clog2(PEAK+1)-1:0]   cnt
);

    localparam int CW = $clog2(PEAK + 1);

    car_dir_e dir;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            dir <= DIR_UP;
        end else if (dir == DIR_UP) begin
            cnt <= cnt + CW'(1);
            if (cnt == CW'(PEAK - 1)) dir <= DIR_DN;
        end else begin
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) dir <= DIR_UP;
        end
    end

    AST_CAR_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= PEAK);                                                   // R1

    AST_CAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(rst)) |->
        ((int'(cnt) == int'($past(cnt)) + 1) || (int'(cnt) == int'($past(cnt)) - 1))); // R1

    AST_CAR_PARK: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0));                                                 // R7

endmodule

// File: rtl/hnpc_leg_cmp.sv
module hnpc_leg_cmp
    import hnpc_pkg::*;
#(
    parameter int PEAK = CAR_PEAK
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          en,
    input  logic [$clog2(2*PEAK+1)-1:0]   ref_in,
    input  logic [$clog2(PEAK+1)-1:0]     car,
    output leg_gates_t                    demand
);

    localparam int RW = $clog2(2 * PEAK + 1);
    localparam int CW = $clog2(PEAK + 1);
    localparam logic [RW-1:0] MID = RW'(PEAK);

    logic [RW-1:0] ref_q;
    logic [CW-1:0] car_q;
    logic          positive;
    logic [RW-1:0] offset;
    logic          fast_on;

    // Capture the reference at the valley; delay the carrier to stay aligned.
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ref_q <= MID;
            car_q <= '0;
        end else begin
            car_q <= car;
            if (car == '0) ref_q <= ref_in;
        end
    end

    always_comb begin
        positive = (ref_q >= MID);
        offset   = positive ? (ref_q - MID) : (MID - ref_q);
        fast_on  = (offset > RW'(car_q));
        demand   = leg_decode(positive, fast_on);
    end

    AST_REF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && car != '0) |=> (!en || $stable(ref_q)));                       // R2

    AST_REF_TAKE: assert property (@(posedge clk) disable iff (rst)
        (en && car == '0) |=> (!en || ref_q == $past(ref_in)));               // R2

endmodule

// File: rtl/hnpc_deadband.sv
module hnpc_deadband #(
    parameter int DELAY = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic din,
    output logic dout
);

    localparam int CW    = $clog2(DELAY + 1);
    localparam int KW    = $clog2(DELAY + 2);
    localparam int K_TOP = DELAY + 1;

    logic [CW-1:0] run;

    // Falling demand clears at once; rising demand must persist DELAY clocks.
    always_ff @(posedge clk) begin
        if (rst || !en || !din) begin
            run  <= '0;
            dout <= 1'b0;
        end else if (run == CW'(DELAY)) begin
            dout <= 1'b1;
        end else begin
            run <= run + CW'(1);
        end
    end

    // Independent watch counter: clocks of uninterrupted demand, saturating.
    logic [KW-1:0] watch;
    always_ff @(posedge clk) begin
        if (rst || !en || !din) watch <= '0;
        else if (watch != KW'(K_TOP)) watch <= watch + KW'(1);
    end

    AST_FALL_FAST: assert property (@(posedge clk) disable iff (rst)
        !din |=> !dout);                                                      // R5

    AST_RISE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        $rose(dout) |-> (watch == KW'(K_TOP)));                               // R6

    AST_OUT_NEEDS_DEMAND: assert property (@(posedge clk) disable iff (rst)
        dout |-> $past(din));                                                 // R5

endmodule

// File: rtl/hnpc_modulator.sv
module hnpc_modulator
    import hnpc_pkg::*;
#(
    parameter int NPH     = NUM_PHASES,
    parameter int PEAK    = CAR_PEAK,
    parameter int DT_IGBT = DT_SLOW,
    parameter int DT_FET  = DT_FAST
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 en,
    input  logic [NPH*$clog2(2*PEAK+1)-1:0]      ref_in,
    output logic [NPH*GATES_PER_LEG-1:0]         gates
);

    localparam int RW = $clog2(2 * PEAK + 1);
    localparam int CW = $clog2(PEAK + 1);
    localparam int GL = GATES_PER_LEG;

    logic [CW-1:0] car;

    hnpc_carrier #(.PEAK(PEAK)) u_carrier (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .cnt (car)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_leg
        leg_gates_t    dem;
        logic [GL-1:0] dem_v;
        logic [GL-1:0] out_v;

        hnpc_leg_cmp #(.PEAK(PEAK)) u_cmp (
            .clk    (clk),
            .rst    (rst),
            .en     (en),
            .ref_in (ref_in[p*RW +: RW]),
            .car    (car),
            .demand (dem)
        );

        assign dem_v = dem;

        for (genvar j = 0; j < GL; j++) begin : g_dev
            if (j < SLOW_PER_LEG) begin : g_slow
                hnpc_deadband #(.DELAY(DT_IGBT)) u_db (
                    .clk  (clk),
                    .rst  (rst),
                    .en   (en),
                    .din  (dem_v[j]),
                    .dout (out_v[j])
                );
            end else begin : g_fast
                hnpc_deadband #(.DELAY(DT_FET)) u_db (
                    .clk  (clk),
                    .rst  (rst),
                    .en   (en),
                    .din  (dem_v[j]),
                    .dout (out_v[j])
                );
            end
        end

        assign gates[p*GL +: GL] = out_v;

        AST_FET_EXCL: assert property (@(posedge clk) disable iff (rst)
            !(out_v[4] && out_v[5]));                                         // R5

        AST_IGBT_EXCL: assert property (@(posedge clk) disable iff (rst)
            !((out_v[0] || out_v[1]) && (out_v[2] || out_v[3])));            // R5

        AST_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
            !en |=> (out_v == '0));                                           // R7
    end

endmodule

// File: tb/hnpc_modulator_bench.sv
module hnpc_modulator_bench;

    localparam int PEAK = 500;
    localparam int DTS  = 9;
    localparam int DTF  = 3;
    localparam int NPH  = 3;
    localparam int RW   = 10;
    localparam int NG   = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [NPH*RW-1:0] ref_in = '0;
    logic [NG-1:0] gates;

    int total = 0;
    int bad   = 0;
    bit finished = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    hnpc_modulator u_hnpc_modulator (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .ref_in (ref_in),
        .gates  (gates)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model (requirements R1 R2 R3 R4) -------------
    function automatic logic [5:0] demand_of(input int r, input int c);
        logic [5:0] d;
        bit pos;
        int off;
        bit fast;
        pos  = (r >= PEAK);
        off  = pos ? r - PEAK : PEAK - r;
        fast = (off > c);
        d[0] = pos; d[1] = pos; d[2] = !pos; d[3] = !pos;
        d[4] = pos ? fast : !fast;
        d[5] = pos ? !fast : fast;
        return d;
    endfunction

    int m_cnt = 0;
    bit m_up = 1;
    int m_car = 0;
    int m_ref [NPH] = '{PEAK, PEAK, PEAK};
    logic [15:0] hist [NG];
    logic [NG-1:0] exp_q [$];

    initial for (int g = 0; g < NG; g++) hist[g] = '0;

    // Model: per edge, derive expected outputs; push them to the scoreboard.
    always @(posedge clk) begin
        logic [NG-1:0] e;
        #1;
        if (rst || !en) begin
            m_cnt = 0; m_up = 1; m_car = 0;
            for (int p = 0; p < NPH; p++) m_ref[p] = PEAK;
            for (int g = 0; g < NG; g++) hist[g] = hist[g] << 1;
        end else begin
            for (int p = 0; p < NPH; p++) begin
                logic [5:0] d;
                d = demand_of(m_ref[p], m_car);
                for (int j = 0; j < 6; j++) hist[p*6+j] = (hist[p*6+j] << 1) | 16'(d[j]);
            end
            m_car = m_cnt;
            if (m_cnt == 0)
                for (int p = 0; p < NPH; p++) m_ref[p] = int'(ref_in[p*RW +: RW]);
            if (m_up) begin
                m_cnt++;
                if (m_cnt == PEAK) m_up = 0;
            end else begin
                m_cnt--;
                if (m_cnt == 0) m_up = 1;
            end
        end
        for (int g = 0; g < NG; g++) begin
            int dt;
            logic [15:0] mask;
            dt = ((g % 6) < 4) ? DTS : DTF;
            mask = 16'((1 << (dt + 1)) - 1);
            e[g] = ((hist[g] & mask) == mask);
        end
        exp_q.push_back(e);
    end

    // Monitor: pop expected vector and compare; track dead-band spacing.
    logic [NG-1:0] prev_g = '0;
    int off_since [NG];
    initial for (int g = 0; g < NG; g++) off_since[g] = 0;

    always @(posedge clk) begin
        logic [NG-1:0] e;
        #2;
        cyc++;
        if (exp_q.size() > 0 && !finished) begin
            e = exp_q.pop_front();
            check_eq("R1 R2 R3 R4", "gate vector vs model", int'(gates), int'(e));
        end
        for (int g = 0; g < NG; g++) begin
            if (gates[g] && !prev_g[g]) begin
                int j;
                int p;
                j = g % 6;
                p = g / 6;
                if (j >= 4) begin : fet_rise
                    int cg;
                    cg = p*6 + ((j == 4) ? 5 : 4);
                    total++;
                    if (gates[cg] || (cyc - off_since[cg]) < DTF) begin
                        bad++;
                        $display("FAIL R5 fet gap leg %0d actual=%0d expected>=%0d", p, cyc - off_since[cg], DTF);
                    end
                end else begin : igbt_rise
                    int b0;
                    int gap;
                    bit on;
                    b0 = (j < 2) ? 2 : 0;
                    on = gates[p*6+b0] || gates[p*6+b0+1];
                    gap = cyc - ((off_since[p*6+b0] > off_since[p*6+b0+1]) ?
                                 off_since[p*6+b0] : off_since[p*6+b0+1]);
                    total++;
                    if (on || gap < DTS) begin
                        bad++;
                        $display("FAIL R5 igbt gap leg %0d actual=%0d expected>=%0d", p, gap, DTS);
                    end
                end
            end
            if (gates[g]) off_since[g] = cyc + 1;
        end
        prev_g = gates;
    end

    // ---------------- driver helpers ----------------
    task automatic set_refs(input int a, input int b, input int c);
        @(negedge clk);
        ref_in = {RW'(c), RW'(b), RW'(a)};
    endtask

    int cnts [NG];
    task automatic count_all(input int n);
        for (int g = 0; g < NG; g++) cnts[g] = 0;
        repeat (n) begin
            @(posedge clk);
            #3;
            for (int g = 0; g < NG; g++) if (gates[g]) cnts[g]++;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // Reset state (R7)
        repeat (5) @(negedge clk);
        check_eq("R7", "gates in reset", int'(gates), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R7", "gates with enable low", int'(gates), 0);

        // Phase 1: steady, positive / negative / midpoint (R3 R4)
        set_refs(750, 250, 500);
        en = 1'b1;
        repeat (2100) @(negedge clk);
        count_all(1000);
        check_eq("R3", "leg a upper outer on", cnts[0], 1000);
        check_eq("R3", "leg a lower outer off", cnts[3], 0);
        check_eq("R4", "leg a upper fet", cnts[4], 496);
        check_eq("R4", "leg a lower fet", cnts[5], 498);
        check_eq("R3", "leg b lower outer on", cnts[9], 1000);
        check_eq("R3", "leg b upper clamp off", cnts[7], 0);
        check_eq("R4", "leg b lower fet", cnts[11], 496);
        check_eq("R4", "leg b upper fet", cnts[10], 498);
        check_eq("R3", "leg c midpoint upper outer", cnts[12], 1000);
        check_eq("R4", "leg c midpoint upper fet", cnts[16], 0);
        check_eq("R4", "leg c midpoint lower fet", cnts[17], 1000);

        // Phase 2: short pulses (R6)
        set_refs(505, 0, 501);
        repeat (2100) @(negedge clk);
        count_all(1000);
        check_eq("R6", "leg a narrow upper fet", cnts[4], 6);
        check_eq("R6", "leg a lower fet", cnts[5], 988);
        check_eq("R6", "leg b one-clock upper fet suppressed", cnts[10], 0);
        check_eq("R6", "leg b lower fet widened dip", cnts[11], 996);
        check_eq("R6", "leg c one-clock upper fet suppressed", cnts[16], 0);
        check_eq("R6", "leg c lower fet", cnts[17], 996);

        // Phase 3: zero crossings on every leg (R3 R5)
        set_refs(495, 1000, 499);
        repeat (2100) @(negedge clk);
        count_all(1000);
        check_eq("R3", "leg a after crossing lower outer", cnts[3], 1000);
        check_eq("R3", "leg a after crossing upper outer", cnts[0], 0);
        check_eq("R5", "leg a lower fet", cnts[5], 6);
        check_eq("R3", "leg b after crossing upper outer", cnts[6], 1000);
        check_eq("R5", "leg b upper fet", cnts[10], 996);
        check_eq("R5", "leg b lower fet", cnts[11], 0);

        // Phase 4: references move mid-period; only valley captures count (R2)
        for (int k = 0; k < 90; k++) begin
            set_refs((k * 137) % 1001, (k * 311 + 77) % 1001, (k * 53 + 400) % 1001);
            repeat (36) @(negedge clk);
        end
        set_refs(600, 400, 500);
        repeat (1500) @(negedge clk);

        // Phase 5: enable dropped mid-period (R7), restart of carrier (R1)
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check_eq("R7", "gates one clock after enable low", int'(gates), 0);
        repeat (5) @(negedge clk);
        check_eq("R7", "gates while disabled", int'(gates), 0);
        en = 1'b1;
        repeat (2100) @(negedge clk);
        count_all(1000);
        check_eq("R1", "leg a upper fet after restart", cnts[4], 196);
        check_eq("R1", "leg b lower fet after restart", cnts[11], 196);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule